// File: doc/BRIEF.md
# Conditional Relative Branch Target Unit

This block works out where an 8-bit processor with a 16-bit address space goes next after a flow-control instruction. Each instruction is presented once, already decoded, along with:

- its opcode byte;
- the four condition flags (negative, zero, carry, overflow);
- the address of the instruction that follows it;
- an 8-bit signed displacement;
- a 16-bit absolute operand.

One cycle later the unit returns four results: the next program counter, a taken indication, the number of cycles the instruction costs beyond its base time, and a one-cycle `done` strobe.

Conditional branches add the displacement to the follow-on address when their flag test passes. An absolute jump loads its operand directly. An indirect jump treats its operand as a pointer and reads the two target bytes through a simple combinational byte-read port, low byte first. While that fetch runs, the unit reports `busy` and ignores new issues. Instruction fetch, the flag register and memory are all outside the block.

Top module: `branch_target_unit`

## Requirements
- R1: During and immediately after reset, `done`, `taken`, `busy` and `ptr_rd` are low, and `next_pc` and `extra_cycles` are zero.
- R2: An opcode is a conditional branch when its bits [4:0] equal 5'b10000. Bits [7:6] then choose the flag tested: 00 negative, 01 overflow, 10 carry, 11 zero. The branch is taken when that flag equals opcode bit 5. This gives 10/30 on N, 50/70 on V, 90/B0 on C and D0/F0 on Z.
- R3: For a taken branch, `next_pc` is `pc_next` plus the sign-extended displacement, modulo 2^16. A displacement byte above 127 moves backwards by 256 minus its value.
- R4: For a branch whose condition fails, `next_pc` equals `pc_next`, `taken` is low and `extra_cycles` is 0.
- R5: A taken branch reports `extra_cycles` = 1 when the target's upper byte equals that of `pc_next`, and 2 when they differ.
- R6: Opcode 4C loads `next_pc` from `abs_operand`, with `taken` high and `extra_cycles` 0.
- R7: For opcode 6C, `ptr_rd` is high for two cycles. The first carries `ptr_addr` = `abs_operand` and the second carries `abs_operand`+1, wrapping at 16 bits. The unit then reports `next_pc` = {second byte, first byte}, with `taken` high and `extra_cycles` 0.
- R8: Any opcode that is neither a branch nor 4C nor 6C yields `next_pc` = `pc_next`, with `taken` low and `extra_cycles` 0.
- R9: Every issue other than 6C raises `done` for exactly one cycle, in the cycle after issue. A 6C issue raises `done` three cycles after issue. Issues presented while `busy` is high are ignored. A new issue is accepted in the same cycle that an indirect result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Opcode byte |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| pc_next | input | 16 | Address of the following instruction |
| branch_off | input | 8 | Signed branch displacement |
| abs_operand | input | 16 | Absolute target or pointer address |
| ptr_rd | output | 1 | Pointer byte read strobe |
| ptr_addr | output | 16 | Pointer byte read address |
| ptr_data | input | 8 | Byte returned combinationally for `ptr_addr` |
| busy | output | 1 | Indirect fetch in progress; issues are ignored |
| done | output | 1 | Result valid this cycle |
| taken | output | 1 | Control flow leaves the sequential path |
| next_pc | output | 16 | Next program counter |
| extra_cycles | output | 2 | Cycles added to the base cost |

## Verification
Two pieces of work can overlap in one cycle. The first is the final step of an indirect pointer fetch. The second is the acceptance of a new issue, either one that must be rejected or one that must be taken back-to-back.

The bench starts an indirect jump and holds a conflicting absolute jump on the inputs throughout the fetch. It then checks three things:
- the pointer addresses are undisturbed;
- the indirect result appears alone first;
- the held jump is accepted in the cycle that result is presented, and its own result follows on the next cycle.

Random issues are mixed with directed wrap cases at 0000/FFFF, and each branch condition is driven with its flag in both states.

// File: rtl/bru_pkg.sv
package bru_pkg;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OP_JMP_ABS = 8'h4C;
   localparam logic [OPC_W-1:0] OP_JMP_IND = 8'h6C;
   localparam logic [4:0]       BR_LOW_PAT = 5'b10000;

   typedef enum logic [1:0] {
      FLG_N = 2'b00,
      FLG_V = 2'b01,
      FLG_C = 2'b10,
      FLG_Z = 2'b11
   } flag_sel_e;

   typedef enum logic [1:0] {
      K_NONE,
      K_BRANCH,
      K_JABS,
      K_JIND
   } op_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PTR_LO,
      ST_PTR_HI
   } fetch_st_e;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
   import bru_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic             fn,
   input  logic             fz,
   input  logic             fc,
   input  logic             fv,
   output op_kind_e         kind,
   output logic             cond_met
);

   flag_sel_e sel;
   logic      flag_val;

   assign sel = flag_sel_e'(opcode[7:6]);

   always_comb begin
      case (sel)
         FLG_N:   flag_val = fn;
         FLG_V:   flag_val = fv;
         FLG_C:   flag_val = fc;
         default: flag_val = fz;
      endcase
   end

   // bit 5 holds the flag value that makes the branch go
   assign cond_met = (flag_val == opcode[5]);

   always_comb begin
      if (opcode[4:0] == BR_LOW_PAT)
         kind = K_BRANCH;
      else if (opcode == OP_JMP_ABS)
         kind = K_JABS;
      else if (opcode == OP_JMP_IND)
         kind = K_JIND;
      else
         kind = K_NONE;
   end

endmodule

// File: rtl/bru_rel_target.sv
module bru_rel_target #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int PAGE_W      = 8,
   parameter int PAGE_DETECT = 0
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DATA_W-1:0] disp,
   output logic [ADDR_W-1:0] target,
   output logic              page_cross
);

   localparam int EXT_W = ADDR_W - DATA_W;
   localparam int HI_W  = ADDR_W - PAGE_W;

   logic [ADDR_W-1:0] disp_ext;

   assign disp_ext = {{EXT_W{disp[DATA_W-1]}}, disp};

   generate
      if (EXT_W < 1) begin : g_bad_ext
         $error("bru_rel_target: ADDR_W must exceed DATA_W");
      end
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("bru_rel_target: PAGE_W out of range");
      end

      if (PAGE_DETECT == 0) begin : g_cmp
         // full-width add, then compare the page numbers
         assign target     = base + disp_ext;
         assign page_cross = (target[ADDR_W-1:PAGE_W] != base[ADDR_W-1:PAGE_W]);
      end else begin : g_carry
         if (DATA_W > PAGE_W) begin : g_bad_carry
            $error("bru_rel_target: carry detect needs DATA_W <= PAGE_W");
         end
         // split add: page change is the low carry against the sign
         logic [PAGE_W:0]  low_sum;
         logic [HI_W-1:0]  hi_sum;
         assign low_sum    = {1'b0, base[PAGE_W-1:0]} + {1'b0, disp_ext[PAGE_W-1:0]};
         assign hi_sum     = base[ADDR_W-1:PAGE_W] + disp_ext[ADDR_W-1:PAGE_W]
                           + {{(HI_W-1){1'b0}}, low_sum[PAGE_W]};
         assign target     = {hi_sum, low_sum[PAGE_W-1:0]};
         assign page_cross = low_sum[PAGE_W] ^ disp[DATA_W-1];
      end
   endgenerate

endmodule

// File: rtl/bru_ind_fetch.sv
module bru_ind_fetch
   import bru_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] ptr_base,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              busy,
   output logic              fin,
   output logic [ADDR_W-1:0] target
);

   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_ratio
         $error("bru_ind_fetch: pointer must assemble from two bytes");
      end
   endgenerate

   fetch_st_e         st;
   logic [ADDR_W-1:0] ptr_q;
   logic [DATA_W-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         ptr_q <= '0;
         lo_q  <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               ptr_q <= ptr_base;
               st    <= ST_PTR_LO;
            end
            ST_PTR_LO: begin
               lo_q <= rd_data;
               st   <= ST_PTR_HI;
            end
            ST_PTR_HI: st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   assign rd_en   = (st != ST_IDLE);
   assign busy    = rd_en;
   assign fin     = (st == ST_PTR_HI);
   assign rd_addr = (st == ST_PTR_HI) ? ptr_q + ONE : ptr_q;
   assign target  = {rd_data, lo_q};

   // R7: the high-byte read sits one address past the low-byte read
   p_hi_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PTR_HI) |-> (rd_addr == $past(rd_addr) + ONE));

   // R9: a fetch begins only on a start request
   p_start_gates_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
   import bru_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int PAGE_W      = 8,
   parameter int PAGE_DETECT = 0,
   parameter int EXTRA_W     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               issue_valid,
   input  logic [7:0]         opcode,
   input  logic               flag_n,
   input  logic               flag_z,
   input  logic               flag_c,
   input  logic               flag_v,
   input  logic [ADDR_W-1:0]  pc_next,
   input  logic [DATA_W-1:0]  branch_off,
   input  logic [ADDR_W-1:0]  abs_operand,
   output logic               ptr_rd,
   output logic [ADDR_W-1:0]  ptr_addr,
   input  logic [DATA_W-1:0]  ptr_data,
   output logic               busy,
   output logic               done,
   output logic               taken,
   output logic [ADDR_W-1:0]  next_pc,
   output logic [EXTRA_W-1:0] extra_cycles
);

   localparam logic [EXTRA_W-1:0] X_NONE  = '0;
   localparam logic [EXTRA_W-1:0] X_TAKEN = EXTRA_W'(1);
   localparam logic [EXTRA_W-1:0] X_PAGE  = EXTRA_W'(2);

   generate
      if (EXTRA_W < 2) begin : g_bad_extra
         $error("branch_target_unit: EXTRA_W must hold the value 2");
      end
   endgenerate

   op_kind_e           kind;
   logic               cond_met;
   logic [ADDR_W-1:0]  rel_target;
   logic               page_cross;
   logic               fetch_busy;
   logic               fetch_fin;
   logic [ADDR_W-1:0]  fetch_target;
   logic               accept;

   logic [ADDR_W-1:0]  nxt_pc;
   logic               nxt_taken;
   logic [EXTRA_W-1:0] nxt_extra;

   logic               done_q;
   logic               taken_q;
   logic [ADDR_W-1:0]  pc_q;
   logic [EXTRA_W-1:0] extra_q;

   bru_decode u_decode (
      .opcode   (opcode),
      .fn       (flag_n),
      .fz       (flag_z),
      .fc       (flag_c),
      .fv       (flag_v),
      .kind     (kind),
      .cond_met (cond_met)
   );

   bru_rel_target #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .PAGE_W      (PAGE_W),
      .PAGE_DETECT (PAGE_DETECT)
   ) u_rel (
      .base       (pc_next),
      .disp       (branch_off),
      .target     (rel_target),
      .page_cross (page_cross)
   );

   assign accept = issue_valid && !fetch_busy;

   bru_ind_fetch #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept && (kind == K_JIND)),
      .ptr_base (abs_operand),
      .rd_data  (ptr_data),
      .rd_en    (ptr_rd),
      .rd_addr  (ptr_addr),
      .busy     (fetch_busy),
      .fin      (fetch_fin),
      .target   (fetch_target)
   );

   always_comb begin
      nxt_pc    = pc_next;
      nxt_taken = 1'b0;
      nxt_extra = X_NONE;
      case (kind)
         K_BRANCH: if (cond_met) begin
            nxt_pc    = rel_target;
            nxt_taken = 1'b1;
            nxt_extra = page_cross ? X_PAGE : X_TAKEN;
         end
         K_JABS: begin
            nxt_pc    = abs_operand;
            nxt_taken = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         taken_q <= 1'b0;
         pc_q    <= '0;
         extra_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (fetch_fin) begin
            done_q  <= 1'b1;
            taken_q <= 1'b1;
            pc_q    <= fetch_target;
            extra_q <= X_NONE;
         end else if (accept && (kind != K_JIND)) begin
            done_q  <= 1'b1;
            taken_q <= nxt_taken;
            pc_q    <= nxt_pc;
            extra_q <= nxt_extra;
         end
      end
   end

   assign busy         = fetch_busy;
   assign done         = done_q;
   assign taken        = taken_q;
   assign next_pc      = pc_q;
   assign extra_cycles = extra_q;

   // R4: a failing branch returns the follow-on address
   p_fail_keeps_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && kind == K_BRANCH && !cond_met) |=>
      (done && !taken && next_pc == $past(pc_next) && extra_cycles == X_NONE));

   // R3: a passing branch lands at base plus the signed displacement
   p_rel_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && kind == K_BRANCH && cond_met) |=>
      (taken && next_pc == $past(pc_next) +
         {{(ADDR_W-DATA_W){$past(branch_off[DATA_W-1])}}, $past(branch_off)}));

   // R5: penalty is 2 exactly when the page number changes
   p_page_penalty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && kind == K_BRANCH && cond_met) |=>
      ((extra_cycles == X_PAGE) ==
       (next_pc[ADDR_W-1:PAGE_W] != $past(pc_next[ADDR_W-1:PAGE_W])) &&
       (extra_cycles == X_PAGE || extra_cycles == X_TAKEN)));

   // R6: absolute jump loads the operand with no penalty
   p_abs_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && kind == K_JABS) |=>
      (done && taken && next_pc == $past(abs_operand) && extra_cycles == X_NONE));

   // R7: the end of a pointer fetch yields a taken, penalty-free result
   p_ind_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_fin |=> (done && taken && extra_cycles == X_NONE));

   // R9: no result appears while a fetch is mid-way
   p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_busy && !fetch_fin) |=> !done);

endmodule

// File: tb/branch_target_unit_tb.sv
module branch_target_unit_tb;

   localparam time CLK_HALF = 10ns;  // 50 MHz

   logic        clk = 1'b0;
   logic        rst_n;
   logic        issue_valid;
   logic [7:0]  opcode;
   logic        flag_n, flag_z, flag_c, flag_v;
   logic [15:0] pc_next;
   logic [7:0]  branch_off;
   logic [15:0] abs_operand;
   logic        ptr_rd;
   logic [15:0] ptr_addr;
   logic [7:0]  ptr_data;
   logic        busy, done, taken;
   logic [15:0] next_pc;
   logic [1:0]  extra_cycles;

   int checks = 0;
   int errors = 0;

   always #(CLK_HALF) clk = ~clk;

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   assign ptr_data = mem_byte(ptr_addr);

   branch_target_unit u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue_valid  (issue_valid),
      .opcode       (opcode),
      .flag_n       (flag_n),
      .flag_z       (flag_z),
      .flag_c       (flag_c),
      .flag_v       (flag_v),
      .pc_next      (pc_next),
      .branch_off   (branch_off),
      .abs_operand  (abs_operand),
      .ptr_rd       (ptr_rd),
      .ptr_addr     (ptr_addr),
      .ptr_data     (ptr_data),
      .busy         (busy),
      .done         (done),
      .taken        (taken),
      .next_pc      (next_pc),
      .extra_cycles (extra_cycles)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] rel_dest(input logic [15:0] pc, input logic [7:0] off);
      if (off > 8'd127) return pc - (16'd256 - {8'h00, off});
      return pc + {8'h00, off};
   endfunction

   function automatic bit is_branch(input logic [7:0] op);
      return op[4:0] == 5'b10000;
   endfunction

   function automatic bit cond_of(input logic [7:0] op, input logic [3:0] f);
      logic fl;
      case (op[7:6])
         2'b00:   fl = f[3];
         2'b01:   fl = f[0];
         2'b10:   fl = f[1];
         default: fl = f[2];
      endcase
      return fl == op[5];
   endfunction

   task automatic drive(input logic [7:0] op, input logic [3:0] f, input logic [15:0] pc,
                        input logic [7:0] off, input logic [15:0] av);
      opcode      = op;
      {flag_n, flag_z, flag_c, flag_v} = f;
      pc_next     = pc;
      branch_off  = off;
      abs_operand = av;
      issue_valid = 1'b1;
   endtask

   // f is {N,Z,C,V}
   task automatic run_op(input logic [7:0] op, input logic [3:0] f, input logic [15:0] pc,
                         input logic [7:0] off, input logic [15:0] av);
      logic [15:0] e_pc;
      logic        e_tk;
      logic [1:0]  e_x;
      string       req;
      e_pc = pc; e_tk = 1'b0; e_x = 2'd0; req = "R8";
      if (is_branch(op)) begin
         if (cond_of(op, f)) begin
            e_pc = rel_dest(pc, off);
            e_tk = 1'b1;
            e_x  = (e_pc[15:8] != pc[15:8]) ? 2'd2 : 2'd1;
            req  = "R2/R3/R5";
         end else begin
            req  = "R2/R4";
         end
      end else if (op == 8'h4C) begin
         e_pc = av; e_tk = 1'b1; req = "R6";
      end else if (op == 8'h6C) begin
         e_pc = {mem_byte(av + 16'd1), mem_byte(av)}; e_tk = 1'b1; req = "R7";
      end
      @(negedge clk);
      chk(done == 1'b0, "R9 idle done", done, 0);
      drive(op, f, pc, off, av);
      @(negedge clk);
      issue_valid = 1'b0;
      if (op == 8'h6C) begin
         chk(busy && ptr_rd && ptr_addr == av, "R7 low read", ptr_addr, av);
         chk(done == 1'b0, "R9 no early done", done, 0);
         @(negedge clk);
         chk(ptr_rd && ptr_addr == av + 16'd1, "R7 high read", ptr_addr, av + 16'd1);
         @(negedge clk);
      end
      chk(done == 1'b1, {req, " done"}, done, 1);
      chk(next_pc == e_pc, {req, " next_pc"}, next_pc, e_pc);
      chk(taken == e_tk, {req, " taken"}, taken, e_tk);
      chk(extra_cycles == e_x, {req, " extra"}, extra_cycles, e_x);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] brs [8];
      logic [15:0] x1, x2;
      brs = '{8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'hD0, 8'hF0};
      void'($urandom(32'd20240531));
      rst_n = 1'b0;
      issue_valid = 1'b0;
      opcode = 8'hEA; {flag_n, flag_z, flag_c, flag_v} = 4'h0;
      pc_next = '0; branch_off = '0; abs_operand = '0;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(!done && !taken && !busy && !ptr_rd, "R1 reset flags",
          {done, taken, busy, ptr_rd}, 0);
      chk(next_pc == 16'h0 && extra_cycles == 2'd0, "R1 reset values",
          {next_pc, extra_cycles}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !busy, "R1 after release", {done, busy}, 0);

      // R2: every branch with its flag in both states, forward and back
      for (int i = 0; i < 8; i++) begin
         run_op(brs[i], 4'b0000, 16'h4000, 8'h10, 16'h0);
         run_op(brs[i], 4'b1111, 16'h4000, 8'hF0, 16'h0);
      end
      // R3/R5: wrap and page edges
      run_op(8'hF0, 4'b0100, 16'hFFF0, 8'h20, 16'h0);   // wraps to 0010
      run_op(8'hD0, 4'b0000, 16'h0005, 8'hF0, 16'h0);   // wraps to FFF5
      run_op(8'h90, 4'b0000, 16'h12FE, 8'h01, 16'h0);   // same page, 12FF
      run_op(8'h90, 4'b0000, 16'h12FF, 8'h01, 16'h0);   // next page
      run_op(8'hB0, 4'b0010, 16'h3480, 8'h7F, 16'h0);   // max forward
      run_op(8'hB0, 4'b0010, 16'h3480, 8'h80, 16'h0);   // max backward, 3400
      run_op(8'hB0, 4'b0010, 16'h3400, 8'h80, 16'h0);   // back across page
      // R6/R7/R8
      run_op(8'h4C, 4'b1010, 16'h1111, 8'h00, 16'hC0DE);
      run_op(8'h6C, 4'b0000, 16'h2222, 8'h00, 16'h0300);
      run_op(8'h6C, 4'b0000, 16'h2222, 8'h00, 16'hFFFF);  // pointer wrap
      run_op(8'hEA, 4'b1111, 16'h5678, 8'h44, 16'h9999);
      run_op(8'h20, 4'b1111, 16'h5678, 8'h44, 16'h9999);

      // R9: issue held during a fetch is ignored, then accepted back-to-back
      @(negedge clk);
      drive(8'h6C, 4'b0000, 16'h0100, 8'h00, 16'h1234);
      @(negedge clk);
      drive(8'h4C, 4'b0000, 16'h0200, 8'h00, 16'hBEEF);
      chk(busy && ptr_addr == 16'h1234, "R9 busy low read", ptr_addr, 16'h1234);
      @(negedge clk);
      chk(ptr_addr == 16'h1235 && !done, "R9 ignored issue", ptr_addr, 16'h1235);
      @(negedge clk);
      x1 = {mem_byte(16'h1235), mem_byte(16'h1234)};
      chk(done && next_pc == x1, "R9 R7 indirect result", next_pc, x1);
      chk(!busy, "R9 free on result", busy, 0);
      @(negedge clk);
      issue_valid = 1'b0;
      chk(done && taken && next_pc == 16'hBEEF, "R9 back-to-back", next_pc, 16'hBEEF);
      @(negedge clk);
      chk(!done, "R9 single pulse", done, 0);

      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [7:0] op;
         logic [3:0] sel;
         sel = 4'($urandom_range(0, 11));
         if (sel < 8) op = brs[sel[2:0]];
         else if (sel == 8) op = 8'h4C;
         else if (sel == 9) op = 8'h6C;
         else begin
            op = 8'($urandom);
            if (op[4:0] == 5'b10000 || op == 8'h4C || op == 8'h6C) op = 8'hEA;
         end
         x2 = 16'($urandom);
         run_op(op, 4'($urandom), x2, 8'($urandom), 16'($urandom));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule